// File: doc/BRIEF.md
# Hierarchical Power Domain Sequencer

This block sequences a small set of power domains that are arranged as a tree, where every domain except the root has one parent. Control software issues one command at a time: a domain index and a direction, on or off. A separate sleep input asks for every domain to be powered down. For each domain the block drives a power-switch enable, a clock-enable flop, an output-isolation enable and a state-save request. It also reports a ready flag, which software can read before it issues the next command. The analog switch, the regulator, the clock source and the save memory lie outside the block. Each of them returns a handshake: voltage good, clock good, save done.

To bring a domain up, the block turns on its power switch and waits for voltage good. It then enables the clock and waits for clock good and for a programmable rush-current settle interval. After that it releases isolation and reports the domain ready. To take a domain down, the block first asks for its state to be saved and waits for save done while the power stays on. It then stops the clock and cuts the power. An off request to a parent first takes down every powered descendant, children before parents. An on request whose parent is not fully on is rejected: a sticky error flag is set and no domain changes state.

Top module: `pd_seq_top`

## Requirements
- R1: While reset is asserted and right after it is released, every domain has pwr_en=0, clk_en=0, iso_en=1, save_req=0 and ready=0, and err=0.
- R2: A legal on command (cmd_valid=1, cmd_on=1, cmd_dom=index) to a domain that is off raises its pwr_en after the sampling edge. clk_en stays 0 until v_ok for that domain is seen high.
- R3: A powering domain becomes ready only after v_ok, c_ok and a settle interval of L cycles in the clock phase, where L is rush_len and rush_len=0 selects 16. With v_ok and c_ok held high, ready rises on the (L+2)th edge counted from the command's sampling edge.
- R4: clk_en of a domain is high only while its pwr_en is high. The clock is stopped before the power is cut.
- R5: An off command raises save_req while pwr_en stays high. pwr_en stays high for as long as save_done is low. Power is cut on the second edge after save_done is sampled high.
- R6: iso_en is high in every state except ready, so isolation is in place before power is cut and is released only once the domain is ready.
- R7: A child has pwr_en high only while its parent has pwr_en high. The default tree: domain 0 is the root, domains 1 and 2 are children of 0, and domain 3 is a child of 1.
- R8: An off command to a parent powers down every powered descendant first. Each child's power falls before its parent's power falls.
- R9: An on command to an off domain whose parent is not ready, or whose parent is already being taken down, sets err. err then stays set until reset, and no domain's outputs change.
- R10: A one-cycle pulse on sleep_req powers down all domains, each child before its parent.
- R11: An on command to a domain that is not off, and an off command to a domain that is off, change nothing and leave err unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled for one cycle |
| cmd_dom | input | IW | Target domain index |
| cmd_on | input | 1 | 1 = power on, 0 = power off |
| sleep_req | input | 1 | Power down all domains |
| rush_len | input | CNTW | Settle interval in cycles, 0 selects the default |
| v_ok | input | NDOM | Per-domain voltage-good indication |
| c_ok | input | NDOM | Per-domain clock-good indication |
| save_done | input | NDOM | Per-domain state-save complete |
| pwr_en | output | NDOM | Power-switch enable |
| clk_en | output | NDOM | Clock-enable flop value |
| iso_en | output | NDOM | Output isolation enable |
| save_req | output | NDOM | State-save request |
| ready | output | NDOM | Domain fully on |
| err | output | 1 | Sticky illegal-request flag |

## Verification
The sequencing is tried with the handshakes held back one at a time: v_ok low, then c_ok low, then save_done low. This shows which wait each phase depends on and that power is never cut early. The settle interval is measured at lengths 1, 4 and the default, which separates an off-by-one in the counter from a wrong default. A table walk builds up and tears down the tree. Its steps include a mid-tree off that must cascade, an on under a powered-off parent, and a root off. The ready and power masks after each step show both the inclusion rule and that a rejected request leaves every domain as it was. The order of the power-fall edges under sleep separates child-first teardown from a simultaneous cut.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [2:0] {
    PD_OFF,
    PD_RAMP,
    PD_SETTLE,
    PD_ON,
    PD_SAVE,
    PD_CUT
  } pd_state_e;
endpackage

// File: rtl/pd_domain_fsm.sv
module pd_domain_fsm
  import pd_pkg::*;
#(
  parameter int CNTW     = 8,
  parameter int RUSH_DEF = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_up,
  input  logic            go_down,
  input  logic            v_ok,
  input  logic            c_ok,
  input  logic            save_done,
  input  logic [CNTW-1:0] rush_len,
  output pd_state_e       state,
  output logic            pwr_en,
  output logic            clk_en,
  output logic            iso_en,
  output logic            save_req,
  output logic            ready
);
  localparam logic [CNTW-1:0] DEF_LEN = CNTW'(RUSH_DEF);
  localparam logic [CNTW-1:0] CNT_MAX = {CNTW{1'b1}};

  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] limit;
  logic            settled;

  assign limit   = (rush_len == '0) ? DEF_LEN : rush_len;
  assign settled = (cnt >= limit - CNTW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PD_OFF;
      cnt   <= '0;
    end else begin
      case (state)
        PD_OFF:    if (go_up) state <= PD_RAMP;
        PD_RAMP:   if (v_ok) begin
                     state <= PD_SETTLE;
                     cnt   <= '0;
                   end
        PD_SETTLE: if (c_ok && settled) state <= PD_ON;
                   else if (cnt != CNT_MAX) cnt <= cnt + CNTW'(1);
        PD_ON:     if (go_down) state <= PD_SAVE;
        PD_SAVE:   if (save_done) state <= PD_CUT;
        PD_CUT:    state <= PD_OFF;
        default:   state <= PD_OFF;
      endcase
    end
  end

  always_comb begin
    pwr_en   = (state != PD_OFF);
    clk_en   = (state == PD_SETTLE) || (state == PD_ON) || (state == PD_SAVE);
    iso_en   = (state != PD_ON);
    save_req = (state == PD_SAVE);
    ready    = (state == PD_ON);
  end
endmodule

// File: rtl/pd_tree_ctl.sv
module pd_tree_ctl
  import pd_pkg::*;
#(
  parameter int                NDOM       = 4,
  parameter int                IW         = 2,
  parameter logic [NDOM*8-1:0] PARENT_MAP = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pd_state_e       st [NDOM],
  input  logic            cmd_valid,
  input  logic [IW-1:0]   cmd_dom,
  input  logic            cmd_on,
  input  logic            sleep_req,
  output logic [NDOM-1:0] go_up,
  output logic [NDOM-1:0] go_down,
  output logic            err
);
  function automatic int parent_of(int i);
    return int'(PARENT_MAP[i*8 +: 8]);
  endfunction

  function automatic logic [NDOM-1:0] anc_mask(int i);
    logic [NDOM-1:0] m;
    int k;
    m = '0;
    k = i;
    for (int d = 0; d < NDOM; d++) begin
      m[k] = 1'b1;
      k = parent_of(k);
    end
    return m;
  endfunction

  function automatic logic [NDOM-1:0] kid_mask(int p);
    logic [NDOM-1:0] m;
    m = '0;
    for (int j = 0; j < NDOM; j++)
      if (j != p && parent_of(j) == p) m[j] = 1'b1;
    return m;
  endfunction

  logic [NDOM-1:0] off_pend, pend_nxt, eff, busy, on_st, par_ok, bad_on;

  for (genvar i = 0; i < NDOM; i++) begin : g_dom
    localparam int              P   = parent_of(i);
    localparam logic [NDOM-1:0] ANC = anc_mask(i);
    localparam logic [NDOM-1:0] KID = kid_mask(i);
    logic hit_on, hit_off;

    assign busy[i]  = (st[i] != PD_OFF);
    assign on_st[i] = (st[i] == PD_ON);
    assign eff[i]   = |(off_pend & ANC);
    assign hit_on   = cmd_valid && cmd_on && (cmd_dom == IW'(i));
    assign hit_off  = (cmd_valid && !cmd_on && (cmd_dom == IW'(i))) || sleep_req;

    if (P == i) begin : g_root
      assign par_ok[i] = 1'b1;
    end else begin : g_kid
      assign par_ok[i] = on_st[P] && !eff[P];
    end

    assign go_up[i]    = hit_on && !busy[i] && par_ok[i];
    assign bad_on[i]   = hit_on && !busy[i] && !par_ok[i];
    assign go_down[i]  = on_st[i] && eff[i] && !(|(busy & KID));
    assign pend_nxt[i] = busy[i] && (off_pend[i] || hit_off);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_pend <= '0;
      err      <= 1'b0;
    end else begin
      off_pend <= pend_nxt;
      err      <= err || (|bad_on);
    end
  end
endmodule

// File: rtl/pd_seq_top.sv
module pd_seq_top
  import pd_pkg::*;
#(
  parameter int                NDOM       = 4,
  parameter int                IW         = $clog2(NDOM),
  parameter int                CNTW       = 8,
  parameter int                RUSH_DEF   = 16,
  parameter logic [NDOM*8-1:0] PARENT_MAP = 32'h01_00_00_00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [IW-1:0]   cmd_dom,
  input  logic            cmd_on,
  input  logic            sleep_req,
  input  logic [CNTW-1:0] rush_len,
  input  logic [NDOM-1:0] v_ok,
  input  logic [NDOM-1:0] c_ok,
  input  logic [NDOM-1:0] save_done,
  output logic [NDOM-1:0] pwr_en,
  output logic [NDOM-1:0] clk_en,
  output logic [NDOM-1:0] iso_en,
  output logic [NDOM-1:0] save_req,
  output logic [NDOM-1:0] ready,
  output logic            err
);
  pd_state_e       st [NDOM];
  logic [NDOM-1:0] go_up, go_down;

  pd_tree_ctl #(.NDOM(NDOM), .IW(IW), .PARENT_MAP(PARENT_MAP)) u_tree (
    .clk(clk), .rst_n(rst_n), .st(st),
    .cmd_valid(cmd_valid), .cmd_dom(cmd_dom), .cmd_on(cmd_on),
    .sleep_req(sleep_req), .go_up(go_up), .go_down(go_down), .err(err)
  );

  for (genvar i = 0; i < NDOM; i++) begin : g_fsm
    pd_domain_fsm #(.CNTW(CNTW), .RUSH_DEF(RUSH_DEF)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .go_up(go_up[i]), .go_down(go_down[i]),
      .v_ok(v_ok[i]), .c_ok(c_ok[i]), .save_done(save_done[i]),
      .rush_len(rush_len), .state(st[i]),
      .pwr_en(pwr_en[i]), .clk_en(clk_en[i]), .iso_en(iso_en[i]),
      .save_req(save_req[i]), .ready(ready[i])
    );
  end
endmodule

// File: rtl/pd_seq_chk.sv
module pd_seq_chk #(
  parameter int                NDOM       = 4,
  parameter logic [NDOM*8-1:0] PARENT_MAP = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDOM-1:0] c_ok,
  input logic [NDOM-1:0] save_done,
  input logic [NDOM-1:0] pwr_en,
  input logic [NDOM-1:0] clk_en,
  input logic [NDOM-1:0] iso_en,
  input logic [NDOM-1:0] save_req,
  input logic [NDOM-1:0] ready,
  input logic            err
);
  for (genvar i = 0; i < NDOM; i++) begin : g_a
    localparam int P = int'(PARENT_MAP[i*8 +: 8]);

    p_clk_needs_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en[i] |-> pwr_en[i]);

    p_cut_after_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en[i]) |-> $past(save_req[i] && save_done[i], 2));

    p_iso_until_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !iso_en[i] |-> ready[i]);

    p_ready_after_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready[i]) |-> $past(c_ok[i]) && $past(clk_en[i]));

    if (P != i) begin : g_kid
      p_child_in_parent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en[i] |-> pwr_en[P]);

      p_parent_saves_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        save_req[P] |-> !pwr_en[i]);
    end
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind pd_seq_top pd_seq_chk #(.NDOM(NDOM), .PARENT_MAP(PARENT_MAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .c_ok(c_ok), .save_done(save_done),
  .pwr_en(pwr_en), .clk_en(clk_en), .iso_en(iso_en),
  .save_req(save_req), .ready(ready), .err(err)
);

// File: tb/tb_pd_seq_top.sv
`timescale 1ns/1ps
module tb_pd_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_dom = '0;
  logic       cmd_on = 1'b0;
  logic       sleep_req = 1'b0;
  logic [7:0] rush_len = '0;
  logic [3:0] v_ok = 4'hF, c_ok = 4'hF, save_done = 4'hF;
  logic [3:0] pwr_en, clk_en, iso_en, save_req, ready;
  logic       err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fall_t [4];
  int incl_viol = 0;
  logic [3:0] prev_pwr = '0;

  pd_seq_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dom(cmd_dom),
    .cmd_on(cmd_on), .sleep_req(sleep_req), .rush_len(rush_len),
    .v_ok(v_ok), .c_ok(c_ok), .save_done(save_done),
    .pwr_en(pwr_en), .clk_en(clk_en), .iso_en(iso_en),
    .save_req(save_req), .ready(ready), .err(err)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // tree: 1,2 under 0; 3 under 1 (R7)
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++)
      if (prev_pwr[i] && !pwr_en[i]) fall_t[i] = cyc;
    prev_pwr = pwr_en;
    if (rst_n && ((pwr_en[3] && !pwr_en[1]) || (pwr_en[1] && !pwr_en[0]) ||
                  (pwr_en[2] && !pwr_en[0])))
      incl_viol++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input int d, input logic on);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dom = 2'(d); cmd_on = on;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0] dom;
    logic       on;
    logic [3:0] mask;
    logic       err;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b1, 4'b0001, 1'b0},
    '{2'd1, 1'b1, 4'b0011, 1'b0},
    '{2'd3, 1'b1, 4'b1011, 1'b0},
    '{2'd2, 1'b1, 4'b1111, 1'b0},
    '{2'd1, 1'b0, 4'b0101, 1'b0},
    '{2'd3, 1'b1, 4'b0101, 1'b1},
    '{2'd1, 1'b1, 4'b0111, 1'b1},
    '{2'd0, 1'b0, 4'b0000, 1'b1}
  };

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    for (int i = 0; i < 4; i++) fall_t[i] = 0;
    repeat (2) @(negedge clk);
    // R1 reset state during and after reset
    check("R1 pwr_en in reset", 32'(pwr_en), 32'h0);
    check("R1 iso_en in reset", 32'(iso_en), 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", {pwr_en, clk_en, save_req, ready, iso_en, 3'b0, err},
          {4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 3'b0, 1'b0});

    // R2/R4: voltage not good, clock stays off
    v_ok[0] = 1'b0; c_ok[0] = 1'b0;
    do_cmd(0, 1'b1);
    check("R2 pwr_en raised", 32'(pwr_en[0]), 32'h1);
    wait_cyc(5);
    check("R2 clk_en held until v_ok", 32'(clk_en[0]), 32'h0);
    check("R6 iso while ramping", 32'(iso_en[0]), 32'h1);
    v_ok[0] = 1'b1;
    wait_cyc(2);
    check("R2 clk_en after v_ok", 32'(clk_en[0]), 32'h1);
    wait_cyc(30);
    check("R3 not ready without c_ok", 32'(ready[0]), 32'h0);
    c_ok[0] = 1'b1;
    wait_cyc(1);
    check("R3 ready after c_ok", 32'(ready[0]), 32'h1);
    check("R6 iso released when ready", 32'(iso_en[0]), 32'h0);

    // R3 settle latency, L=4 then L=1
    rush_len = 8'd4;
    do_cmd(1, 1'b1);
    n = 0;
    while (!ready[1] && n < 100) begin @(posedge clk); n++; @(negedge clk); end
    check("R3 latency L=4", 32'(n), 32'd5);
    rush_len = 8'd1;
    do_cmd(2, 1'b1);
    n = 0;
    while (!ready[2] && n < 100) begin @(posedge clk); n++; @(negedge clk); end
    check("R3 latency L=1", 32'(n), 32'd2);
    rush_len = 8'd0;

    // R11 ignored commands
    do_cmd(1, 1'b1);
    do_cmd(3, 1'b0);
    wait_cyc(4);
    check("R11 ignored cmds keep state", {28'b0, ready}, 32'h7);
    check("R11 no err", 32'(err), 32'h0);

    // R5 save handshake gates power cut
    save_done[1] = 1'b0;
    do_cmd(1, 1'b0);
    wait_cyc(10);
    check("R5 save_req raised", 32'(save_req[1]), 32'h1);
    check("R5 power held during save", 32'(pwr_en[1]), 32'h1);
    check("R6 iso during save", 32'(iso_en[1]), 32'h1);
    save_done[1] = 1'b1;
    @(negedge clk);
    check("R5 power on one edge after done", 32'(pwr_en[1]), 32'h1);
    check("R4 clock stopped before cut", 32'(clk_en[1]), 32'h0);
    @(negedge clk);
    check("R5 power cut two edges after done", 32'(pwr_en[1]), 32'h0);

    // R9 illegal: child of an off parent
    do_cmd(3, 1'b1);
    wait_cyc(4);
    check("R9 err set", 32'(err), 32'h1);
    check("R9 no state change", {28'b0, pwr_en}, 32'h5);

    // R10 sleep: all off, child first
    do_reset();
    do_cmd(0, 1'b1); wait_cyc(25);
    do_cmd(1, 1'b1); wait_cyc(25);
    do_cmd(3, 1'b1); do_cmd(2, 1'b1); wait_cyc(25);
    check("R10 all up before sleep", 32'(ready), 32'hF);
    incl_viol = 0;
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    wait_cyc(30);
    check("R10 all off after sleep", 32'(pwr_en), 32'h0);
    check("R10 d3 before d1", 32'(fall_t[3] < fall_t[1]), 32'h1);
    check("R10 d1 before d0", 32'(fall_t[1] < fall_t[0]), 32'h1);
    check("R10 d2 before d0", 32'(fall_t[2] < fall_t[0]), 32'h1);

    // table walk
    do_reset();
    foreach (VEC[k]) begin
      do_cmd(int'(VEC[k].dom), VEC[k].on);
      wait_cyc(40);
      check($sformatf("R8 R9 table step %0d ready", k), 32'(ready), 32'(VEC[k].mask));
      check($sformatf("R7 table step %0d pwr", k), 32'(pwr_en), 32'(VEC[k].mask));
      check($sformatf("R9 table step %0d err", k), 32'(err), 32'(VEC[k].err));
    end
    check("R8 root off: d1 fell before d0", 32'(fall_t[1] < fall_t[0]), 32'h1);
    check("R7 inclusion never broken", 32'(incl_viol), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule